// File: doc/BRIEF.md
# Serial EEPROM Word Address Counter

This block keeps the internal byte address of a two-wire serial EEPROM. The bus controller loads it from the two address bytes it receives after the device select: an upper byte strobe and a lower byte strobe, each with its own byte input. After every data byte moves over the bus, the controller pulses a step strobe, and the counter advances to the next byte.

The advance follows the direction of the current transfer. In write mode only the offset inside the 64-byte page counts up, so a long burst of writes circles within one page and never spills into the next. In read mode the full address counts up, and it returns to zero after the top of the array. The register holds its value between transactions. A read that sends no address therefore continues from one past the last byte accessed.

The default build has 15 address bits for a 32,768-byte array. Setting the address width to 14 gives the 16,384-byte variant.

Top module: `waddr_ctr`

## Requirements
- R1: While rst_ni is low, addr_o is 0.
- R2: A cycle with ld_hi_i high loads addr_o[14:8] from hi_byte_i[6:0]. The top bit hi_byte_i[7] is ignored, and addr_o[7:0] keeps its value.
- R3: A cycle with ld_lo_i high loads addr_o[7:0] from lo_byte_i, and addr_o[14:8] keeps its value.
- R4: A step (step_i high, no load) with rd_mode_i low (write) adds 1 to addr_o[5:0] modulo 64 and leaves addr_o[14:6] unchanged. Offset 63 therefore goes to offset 0 of the same page.
- R5: A step with rd_mode_i high (read) adds 1 to the whole of addr_o modulo 32768, so 0x7FFF goes to 0x0000 and page boundaries are crossed.
- R6: When a load strobe and step_i are high in the same cycle, the load applies and no increment is made. The half that is not loaded keeps its value.
- R7: With no strobe high, addr_o holds its value for any number of cycles, whatever the value of rd_mode_i.
- R8: With ld_hi_i and ld_lo_i high together, both halves load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_hi_i | input | 1 | Load the upper address byte |
| ld_lo_i | input | 1 | Load the lower address byte |
| hi_byte_i | input | 8 | Received upper address byte |
| lo_byte_i | input | 8 | Received lower address byte |
| step_i | input | 1 | A byte was transferred; advance the address |
| rd_mode_i | input | 1 | 1 = read (wrap the full array), 0 = write (wrap within the page) |
| addr_o | output | 15 | Current word address |

## Verification
A fault in the page/offset split or in the mode select shows up at addr_o on the first step across a boundary. A bad page split makes a write burst move into the next page at offset 63 instead of circling back. A bad mode select makes a read stop at the page edge or miss the wrap at the top of the array. Since addr_o is the register itself, any wrong next value appears one clock after the strobe that caused it.

The sweeps are laid out to reach those boundaries. They cover every upper-byte and lower-byte value, full write circles, a read run through 0x7FFF, and loads that collide with steps. A corrupted bit therefore appears in the check of the very cycle that produced it.

// File: rtl/waddr_pkg.sv
package waddr_pkg;
  typedef enum logic {
    MODE_WR = 1'b0,
    MODE_RD = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/waddr_step.sv
module waddr_step
  import waddr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 6
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  xfer_mode_e        mode_i,
  output logic [ADDR_W-1:0] nxt_o
);
  logic [ADDR_W-1:0] lin_nxt;
  logic [ADDR_W-1:0] page_nxt;

  assign lin_nxt = cur_i + ADDR_W'(1);

  generate
    if (OFF_W >= ADDR_W) begin : g_page_is_array
      assign page_nxt = lin_nxt;
    end else begin : g_page_split
      logic [OFF_W-1:0] off_nxt;
      assign off_nxt  = cur_i[OFF_W-1:0] + OFF_W'(1);
      // page bits held, offset wraps inside page
      assign page_nxt = {cur_i[ADDR_W-1:OFF_W], off_nxt};
    end
  endgenerate

  assign nxt_o = (mode_i == MODE_RD) ? lin_nxt : page_nxt;
endmodule

// File: rtl/waddr_load.sv
module waddr_load #(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [7:0]        hi_byte_i,
  input  logic [7:0]        lo_byte_i,
  output logic [ADDR_W-1:0] nxt_o
);
  localparam int HI_W = ADDR_W - 8;

  generate
    if (HI_W < 8) begin : g_hi_trunc
      logic unused_hi_bits;
      assign unused_hi_bits = ^hi_byte_i[7:HI_W];
    end
  endgenerate

  always_comb begin
    nxt_o = cur_i;
    if (ld_hi_i) nxt_o[ADDR_W-1:8] = hi_byte_i[HI_W-1:0];
    if (ld_lo_i) nxt_o[7:0] = lo_byte_i;
  end
endmodule

// File: rtl/waddr_ctr.sv
module waddr_ctr
  import waddr_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [7:0]        hi_byte_i,
  input  logic [7:0]        lo_byte_i,
  input  logic              step_i,
  input  logic              rd_mode_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] ld_nxt;
  logic [ADDR_W-1:0] step_nxt;
  logic [ADDR_W-1:0] addr_d;
  xfer_mode_e        mode;

  assign mode = xfer_mode_e'(rd_mode_i);

  waddr_load #(.ADDR_W(ADDR_W)) u_load (
    .cur_i    (addr_q),
    .ld_hi_i  (ld_hi_i),
    .ld_lo_i  (ld_lo_i),
    .hi_byte_i(hi_byte_i),
    .lo_byte_i(lo_byte_i),
    .nxt_o    (ld_nxt)
  );

  waddr_step #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_step (
    .cur_i (addr_q),
    .mode_i(mode),
    .nxt_o (step_nxt)
  );

  // load outranks step
  always_comb begin
    if (ld_hi_i || ld_lo_i) addr_d = ld_nxt;
    else if (step_i)        addr_d = step_nxt;
    else                    addr_d = addr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/waddr_chk.sv
module waddr_chk #(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_hi_i,
  input logic              ld_lo_i,
  input logic [7:0]        hi_byte_i,
  input logic [7:0]        lo_byte_i,
  input logic              step_i,
  input logic              rd_mode_i,
  input logic [ADDR_W-1:0] addr_o
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int HI_W  = ADDR_W - 8;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_zero_r1: assert (addr_o == '0);
    end
  end

  p_ld_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_hi_i |=> addr_o[ADDR_W-1:8] == $past(hi_byte_i[HI_W-1:0]));

  p_ld_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_lo_i |=> addr_o[7:0] == $past(lo_byte_i));

  p_wr_page_kept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !rd_mode_i && !ld_hi_i && !ld_lo_i) |=>
      (addr_o[ADDR_W-1:OFF_W] == $past(addr_o[ADDR_W-1:OFF_W])) &&
      (addr_o[OFF_W-1:0] == $past(addr_o[OFF_W-1:0]) + OFF_W'(1)));

  p_rd_linear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && rd_mode_i && !ld_hi_i && !ld_lo_i) |=>
      addr_o == $past(addr_o) + ADDR_W'(1));

  p_load_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && ld_lo_i && !ld_hi_i) |=>
      addr_o[ADDR_W-1:8] == $past(addr_o[ADDR_W-1:8]));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !ld_hi_i && !ld_lo_i) |=> $stable(addr_o));
endmodule

bind waddr_ctr waddr_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ld_hi_i  (ld_hi_i),
  .ld_lo_i  (ld_lo_i),
  .hi_byte_i(hi_byte_i),
  .lo_byte_i(lo_byte_i),
  .step_i   (step_i),
  .rd_mode_i(rd_mode_i),
  .addr_o   (addr_o)
);

// File: tb/waddr_ctr_tb_top.sv
module waddr_ctr_tb_top;
  localparam int AW = 15;
  localparam int ASIZE = 32768;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_hi = 1'b0, ld_lo = 1'b0, step = 1'b0, rd = 1'b0;
  logic [7:0]    hb = '0, lb = '0;
  logic [AW-1:0] addr;

  int n_run = 0;
  int n_fail = 0;
  int exp_a = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  waddr_ctr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ld_hi_i(ld_hi), .ld_lo_i(ld_lo),
    .hi_byte_i(hb), .lo_byte_i(lb), .step_i(step), .rd_mode_i(rd),
    .addr_o(addr)
  );

  task automatic check(input string req);
    n_run++;
    if (int'(addr) != exp_a) begin
      n_fail++;
      $display("FAIL %s: addr=%h expected=%h", req, addr, exp_a[AW-1:0]);
    end
  endtask

  // apply one cycle of strobes, update model, check after the edge
  task automatic op(input bit h, input bit l, input int hv, input int lv,
                    input bit s, input bit r, input string req);
    @(negedge clk);
    ld_hi = h; ld_lo = l; hb = 8'(hv); lb = 8'(lv); step = s; rd = r;
    if (h || l) begin
      if (h) exp_a = ((hv % 128) << 8) | (exp_a & 255);
      if (l) exp_a = (exp_a & 32512) | (lv & 255);
    end else if (s) begin
      if (r) exp_a = (exp_a + 1) % ASIZE;
      else   exp_a = (exp_a & ~63) | ((exp_a + 1) & 63);
    end
    @(posedge clk);
    #2;
    ld_hi = 0; ld_lo = 0; step = 0;
    check(req);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    exp_a = 0;
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R2: every upper byte value, bit 7 ignored
    op(0, 1, 0, 8'h5A, 0, 0, "R3");
    for (int v = 0; v < 256; v++) op(1, 0, v, 0, 0, 0, "R2");
    // R3: every lower byte value, upper kept
    for (int v = 0; v < 256; v++) op(0, 1, 0, v, 0, 1, "R3");
    // R8: both halves together
    op(1, 1, 8'h92, 8'h34, 0, 0, "R8");
    op(1, 1, 8'h7F, 8'hFF, 0, 1, "R8");

    // R4: write circles inside several pages
    for (int p = 0; p < 4; p++) begin
      op(1, 1, (p * 37) >> 2, ((p * 37) << 6) | (p * 11), 0, 0, "R8");
      for (int k = 0; k < 70; k++) op(0, 0, 0, 0, 1, 0, "R4");
    end
    op(1, 1, 8'h7F, 8'hFF, 0, 0, "R8");
    for (int k = 0; k < 3; k++) op(0, 0, 0, 0, 1, 0, "R4");

    // R5: read run through top of array and page boundaries
    op(1, 1, 8'h7F, 8'hE8, 0, 1, "R8");
    for (int k = 0; k < 150; k++) op(0, 0, 0, 0, 1, 1, "R5");

    // R6: load beats step
    op(0, 1, 0, 8'h3F, 1, 1, "R6");
    op(1, 0, 8'h15, 0, 1, 0, "R6");
    op(1, 1, 8'h01, 8'h02, 1, 1, "R6");
    op(0, 0, 0, 0, 1, 0, "R4");

    // R7: hold with mode toggling
    for (int k = 0; k < 20; k++) op(0, 0, 8'hFF, 8'hFF, 0, k % 2, "R7");
    // current-address continuation after idle
    op(0, 0, 0, 0, 1, 1, "R5");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule